// File: doc/BRIEF.md
# Input-Port Transfer Controller

This block sits beside one input FIFO of a packet router. Each router has one copy per input port, and all copies run side by side. The block watches the head word of its first-word-fall-through FIFO. It decides when that word may move through the crossbar, then pulses the FIFO read strobe and the matching output write strobe together. The grant comes from either of two sources. One is the arbiter, when it names this port as the priority channel for the direction. The other is the router-wide busy map, when it shows the direction is free. In both cases the target output FIFO must have room.

Once a port wins a direction, it claims that direction on the busy map and keeps the claim until the last flit of the packet has been written. The last flit is the one whose low four control bits read 1001. Flits of different packets therefore never interleave in one output. While a transfer waits, nothing is read or dropped.

On the receive side, the block raises an almost-full flag when the FIFO fill level leaves room for only one full packet. It admits upstream words only while that flag is low.

Top module: `port_xfer_ctrl`

## Requirements
- R1: While reset is held, in_pop, out_wr and claim_map are all zero and out_data is zero.
- R2: A transfer is a single cycle in which in_pop is high, out_wr is one-hot on the chosen direction, and out_data equals in_head. A head word bound for a direction that is not busy and not full is transferred.
- R3: When the arbiter marks this port as priority for the head word's direction (prio_map bit set), the word is transferred even if busy_map shows that direction busy.
- R4: When the head word's direction is busy, not prioritised for this port, and unclaimed by this port, there is no in_pop and no out_wr, and the word stays at the FIFO head.
- R5: A set out_full bit for the target direction blocks the transfer, even when the port holds priority.
- R6: in_pop is never high on two consecutive cycles, so no new word is read before the current one is written.
- R7: claim_map becomes one-hot on the direction at the first transfer of a packet. It stays set until the cycle after the flit with bits [3:0] equal to 4'b1001 is written, and is then zero.
- R8: While a claim is held, every later flit goes to the claimed direction, whatever route_dir, busy_map and prio_map say.
- R9: in_afull is high exactly when in_level is at least DEPTH minus PKT_FLITS (1012 with the defaults).
- R10: in_push follows rx_valid while in_afull is low and is zero while in_afull is high.
- R11: With the FIFO empty, in_pop stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Upstream receive path has a word ready |
| in_push | output | 1 | Write strobe into the input FIFO |
| in_afull | output | 1 | Input FIFO has room for only one more packet |
| in_level | input | CNT_W (11) | Input FIFO fill level |
| in_empty | input | 1 | Input FIFO is empty |
| in_head | input | DATA_W (64) | Head word of the input FIFO (fall-through) |
| route_dir | input | DIR_W (4) | Direction computed for the head word |
| prio_map | input | NDIR (9) | Directions for which this port is the arbiter's priority channel |
| busy_map | input | NDIR (9) | Directions currently claimed by other ports |
| out_full | input | NDIR (9) | Full flags of the output FIFOs |
| in_pop | output | 1 | Read strobe of the input FIFO |
| out_wr | output | NDIR (9) | One-hot write strobe toward the output FIFOs |
| out_data | output | DATA_W (64) | Word written through the crossbar |
| claim_map | output | NDIR (9) | This port's claim on the busy map |

## Verification
The bench goes after a head word stuck behind a busy direction that is later released by a single priority cycle. A controller that ignored priority would stall forever. One that read ahead would pop words it could not place. It changes route_dir and raises busy on the claimed direction in the middle of a packet. A controller that re-routed tail flits, or dropped its claim early, would split the packet across two outputs. It holds an output full while priority is granted, which catches a design that lets priority bypass the space check. It also fills the FIFO to the packet-headroom level, where an off-by-one threshold would either admit one word too many or refuse one word too early.

// File: rtl/port_xfer_ctrl.sv
module port_xfer_ctrl #(
  parameter int DATA_W    = 64,
  parameter int NDIR      = 9,
  parameter int DEPTH     = 1024,
  parameter int PKT_FLITS = 12,
  parameter int CTRL_W    = 4,
  parameter logic [3:0] LAST_CODE = 4'b1001,
  localparam int DIR_W    = $clog2(NDIR),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AF_LEVEL = DEPTH - PKT_FLITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              in_push,
  output logic              in_afull,
  input  logic [CNT_W-1:0]  in_level,
  input  logic              in_empty,
  input  logic [DATA_W-1:0] in_head,
  input  logic [DIR_W-1:0]  route_dir,
  input  logic [NDIR-1:0]   prio_map,
  input  logic [NDIR-1:0]   busy_map,
  input  logic [NDIR-1:0]   out_full,
  output logic              in_pop,
  output logic [NDIR-1:0]   out_wr,
  output logic [DATA_W-1:0] out_data,
  output logic [NDIR-1:0]   claim_map
);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_XFER} st_t;

  st_t             st;
  logic [DIR_W-1:0] dir_q;
  logic [DIR_W-1:0] cur_dir;
  logic             hold;
  logic             go;
  logic             is_last;

  assign in_afull  = in_level >= CNT_W'(AF_LEVEL);
  assign in_push   = rx_valid & ~in_afull;
  assign cur_dir   = hold ? dir_q : route_dir;
  assign go        = (hold | prio_map[cur_dir] | ~busy_map[cur_dir]) & ~out_full[cur_dir];
  assign is_last   = in_head[CTRL_W-1:0] == CTRL_W'(LAST_CODE);
  assign in_pop    = st == S_XFER;
  assign out_wr    = in_pop ? (NDIR'(1) << dir_q) : '0;
  assign out_data  = in_pop ? in_head : '0;
  assign claim_map = hold ? (NDIR'(1) << dir_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hold  <= 1'b0;
      dir_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (!in_empty) st <= S_PEND;
        S_PEND: begin
          if (in_empty) st <= S_IDLE;
          else if (go) begin
            st    <= S_XFER;
            dir_q <= cur_dir;
            hold  <= 1'b1;
          end
        end
        S_XFER: begin
          st <= (in_level > CNT_W'(1)) ? S_PEND : S_IDLE;
          if (is_last) hold <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_cycle_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |=> !in_pop);

  p_write_pairs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> ($onehot(out_wr) && !in_empty));

  p_room_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_wr) |-> ((out_wr & $past(out_full)) == '0));

  p_busy_needs_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_wr) && !$past(hold)) |-> ((out_wr & $past(busy_map & ~prio_map)) == '0));

  p_claim_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((claim_map != '0) && !in_pop) |=> $stable(claim_map));

  p_claim_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_map));

  p_no_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_empty |-> !in_pop);

endmodule

// File: tb/port_xfer_ctrl_tb_top.sv
module port_xfer_ctrl_tb_top;
  localparam int NDIR = 9;
  localparam int AF   = 1012;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        in_push, in_afull, in_pop;
  logic [10:0] in_level = '0;
  logic        in_empty = 1'b1;
  logic [63:0] in_head = '0;
  logic [3:0]  route_dir = '0;
  logic [8:0]  prio_map = '0, busy_map = '0, out_full = '0;
  logic [8:0]  out_wr, claim_map;
  logic [63:0] out_data;

  port_xfer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .in_push(in_push), .in_afull(in_afull),
    .in_level(in_level), .in_empty(in_empty), .in_head(in_head), .route_dir(route_dir),
    .prio_map(prio_map), .busy_map(busy_map), .out_full(out_full), .in_pop(in_pop),
    .out_wr(out_wr), .out_data(out_data), .claim_map(claim_map)
  );

  always #10 clk = ~clk;

  logic [63:0] q[$];
  logic [63:0] tx[$];
  int m_st = 0, m_dir = 0, m_hold = 0;
  int wr_cnt[NDIR];
  int n_cmp = 0, n_bad = 0, cycles = 0;
  int pops_seen = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit pop, push, g;
    int cd;
    pop  = (m_st == 2);
    push = (tx.size() > 0) && (q.size() < AF);
    if (!rst_n) begin
      m_st = 0; m_hold = 0; m_dir = 0;
    end else begin
      case (m_st)
        0: if (q.size() > 0) m_st = 1;
        1: begin
          if (q.size() == 0) m_st = 0;
          else begin
            cd = m_hold ? m_dir : int'(route_dir);
            g  = (m_hold != 0 || prio_map[cd] || !busy_map[cd]) && !out_full[cd];
            if (g) begin m_st = 2; m_dir = cd; m_hold = 1; end
          end
        end
        default: begin
          m_st = (q.size() > 1) ? 1 : 0;
          if (q[0][3:0] == 4'b1001) m_hold = 0;
        end
      endcase
    end
    if (pop) void'(q.pop_front());
    if (push) q.push_back(tx.pop_front());
    rx_valid = tx.size() > 0;
    in_level = 11'(q.size());
    in_empty = q.size() == 0;
    in_head  = (q.size() > 0) ? q[0] : '0;
  endtask

  task automatic compare();
    logic [8:0]  e_wr, e_claim;
    logic [63:0] e_data;
    bit e_pop, e_af, e_push;
    e_pop   = rst_n && m_st == 2;
    e_wr    = e_pop ? (9'd1 << m_dir) : '0;
    e_data  = e_pop ? q[0] : '0;
    e_claim = (rst_n && m_hold != 0) ? (9'd1 << m_dir) : '0;
    e_af    = q.size() >= AF;
    e_push  = rx_valid && !e_af;
    chk(in_pop === e_pop, "R6 in_pop", in_pop, e_pop);
    chk(out_wr === e_wr, "R2 out_wr", out_wr, e_wr);
    chk(out_data === e_data, "R2 out_data", out_data, e_data);
    chk(claim_map === e_claim, "R7 claim_map", claim_map, e_claim);
    chk(in_afull === e_af, "R9 in_afull", in_afull, e_af);
    chk(in_push === e_push, "R10 in_push", in_push, e_push);
    for (int d = 0; d < NDIR; d++) if (out_wr[d]) wr_cnt[d]++;
    if (in_pop) pops_seen++;
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      model_edge();
      @(negedge clk);
      compare();
      cycles++;
    end
  endtask

  task automatic add_pkt(input logic [7:0] tag);
    for (int i = 0; i < 10; i++) tx.push_back({tag, 52'(i + 100), 4'(i)});
  endtask

  initial begin
    for (int d = 0; d < NDIR; d++) wr_cnt[d] = 0;
    cyc(3);
    chk(in_pop == 0 && out_wr == 0 && claim_map == 0 && out_data == 0, "R1 reset", out_wr, 0);
    rst_n = 1'b1;
    cyc(2);

    route_dir = 4'd3;
    add_pkt(8'hA1);
    cyc(40);
    chk(wr_cnt[3] == 10, "R2 free path", wr_cnt[3], 10);
    chk(claim_map == 0, "R7 release after last", claim_map, 0);

    route_dir = 4'd5; busy_map = 9'b000100000;
    add_pkt(8'hB2);
    cyc(20);
    chk(wr_cnt[5] == 0, "R4 stalled writes", wr_cnt[5], 0);
    chk(q.size() == 10, "R4 head kept", q.size(), 10);
    prio_map = 9'b000100000;
    cyc(1);
    prio_map = '0;
    cyc(40);
    chk(wr_cnt[5] == 10, "R3 priority then claim", wr_cnt[5], 10);
    busy_map = '0;

    route_dir = 4'd6; out_full = 9'b001000000; prio_map = 9'b001000000;
    add_pkt(8'hC3);
    cyc(20);
    chk(wr_cnt[6] == 0, "R5 full blocks prio", wr_cnt[6], 0);
    out_full = '0; prio_map = '0;
    cyc(40);
    chk(wr_cnt[6] == 10, "R5 drains after room", wr_cnt[6], 10);

    route_dir = 4'd2;
    add_pkt(8'hD4);
    cyc(8);
    route_dir = 4'd7; busy_map = 9'b000000100;
    cyc(40);
    chk(wr_cnt[2] == 10, "R8 claimed dir kept", wr_cnt[2], 10);
    chk(wr_cnt[7] == 0, "R8 no reroute", wr_cnt[7], 0);
    busy_map = '0;

    route_dir = 4'd0; busy_map = 9'b000000001;
    for (int i = 0; i < 1020; i++) tx.push_back({8'hE5, 52'(i), 4'd0});
    cyc(1040);
    chk(in_afull == 1'b1, "R9 afull at threshold", in_afull, 1);
    chk(in_level == 11'd1012, "R10 admission stops", in_level, 1012);
    chk(in_push == 1'b0, "R10 push held off", in_push, 0);
    busy_map = '0;
    cyc(2200);
    chk(wr_cnt[0] == 1020, "R9 all words drained", wr_cnt[0], 1020);
    pops_seen = 0;
    cyc(20);
    chk(pops_seen == 0, "R11 idle when empty", pops_seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule